// File: doc/BRIEF.md
# Latching BCD Seven-Segment Digit Driver

This block is a single digit position of a gated frequency or event counter display. The decade counter in front of it presents a 4-bit BCD value that keeps changing while the gate is open. The driver copies that value into its own register only when the load control is raised. Between loads it keeps showing the stored digit, so the rolling count never appears on the display.

The stored code is decoded to seven segment lines and a decimal-point line. All eight outputs pass through a polarity stage that is inverted when the phase input is high. A common-cathode LED display uses phase tied low. A common-anode LED display uses phase tied high. An LCD uses the same square wave on phase that drives its backplane, and the segments then receive AC drive.

A blank input turns every output off immediately. The display also stays dark from reset until the first load. The counter stage is a plain register feed with no back-pressure. The value is sampled on the clock edge where load is high, and there is no valid/ready handshake because the digit can always accept a value.

Top module: `bcd_digit_driver`

## Requirements
- R1: On a rising clock edge with `load` high, `bcd_in` is captured, and its decoded pattern appears on the outputs from that edge on.
- R2: While `load` is low, the stored digit is held, and `seg_out` does not change whatever `bcd_in` does.
- R3: `bcd_in[3]` is the most significant bit of the code. `seg_out` bit 0 is segment a and bit 6 is segment g. With phase low, codes 0..9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R4: Stored codes 10 through 15 turn all seven segments off.
- R5: `blank` high turns all segments and the decimal point off, combinationally, in the same cycle.
- R6: With `phase` low an output that is on reads 1. With `phase` high every output, `dp_out` included, is inverted combinationally, so an off output then reads 1.
- R7: The decimal point is on exactly when `dp_pos` equals the parameter `DIGIT_POS` (default 2).
- R8: After reset every output is off until the first load.
- R9: A load taken while `blank` is high still stores the digit, and the digit shows as soon as `blank` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4 | BCD digit from the decade counter, bit 3 is the MSB |
| load | input | 1 | Capture strobe; the digit is latched on an edge where it is high |
| blank | input | 1 | Forces all outputs off |
| phase | input | 1 | Output polarity; low for common cathode, high for common anode, square wave for LCD |
| dp_pos | input | POS_W (3) | Index of the digit that carries the decimal point |
| seg_out | output | 7 | Segments a (bit 0) to g (bit 6) after polarity |
| dp_out | output | 1 | Decimal point after polarity |

## Verification
A corrupted digit register shows up as a wrong segment pattern on the first cycle after the faulty edge. It then persists until the next load, so a hold test that steps `bcd_in` while `load` is low catches it within one cycle. A wrong "shown" flag shows up as lit segments straight after reset or dark segments after a load. A polarity fault shows up in the same cycle that `phase` changes, because the inversion is combinational.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int SEG_N  = 7;
  localparam int CODE_W = 4;
  localparam int CODES  = 1 << CODE_W;

  typedef logic [SEG_N-1:0]  seg_t;
  typedef logic [CODE_W-1:0] bcd_t;

  // glyph for one code, segment a at bit 0; non-decimal codes are dark
  function automatic seg_t glyph(input bcd_t c);
    seg_t g;
    case (c)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7D;
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h6F;
      default: g = 7'h00;
    endcase
    return g;
  endfunction

  // truth column of one segment across every code value
  function automatic logic [CODES-1:0] seg_column(input int s);
    logic [CODES-1:0] m;
    seg_t g;
    for (int c = 0; c < CODES; c++) begin
      g = glyph(bcd_t'(c));
      m[c] = g[s];
    end
    return m;
  endfunction
endpackage

// File: rtl/digit_store.sv
module digit_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         shown
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      shown <= 1'b0;
    end else if (load) begin
      q     <= d;
      shown <= 1'b1;
    end
  end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import bcd7_pkg::*;
(
  input  bcd_t code,
  output seg_t seg
);
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    localparam logic [CODES-1:0] COLUMN = seg_column(s);
    assign seg[s] = COLUMN[code];
  end
endmodule

// File: rtl/seg_drive.sv
module seg_drive #(
  parameter int N = 8
) (
  input  logic [N-1:0] raw,
  input  logic         off,
  input  logic         phase,
  output logic [N-1:0] drv
);
  logic [N-1:0] gated;
  for (genvar i = 0; i < N; i++) begin : g_line
    assign gated[i] = raw[i] & ~off;
    assign drv[i]   = gated[i] ^ phase;
  end
endmodule

// File: rtl/bcd_digit_driver.sv
module bcd_digit_driver
  import bcd7_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  parameter int DIGIT_POS  = 2,
  localparam int POS_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bcd_in,
  input  logic             load,
  input  logic             blank,
  input  logic             phase,
  input  logic [POS_W-1:0] dp_pos,
  output logic [6:0]       seg_out,
  output logic             dp_out
);
  bcd_t stored_q;
  logic shown_q;
  seg_t seg_raw;
  logic dp_raw;
  logic [SEG_N:0] drv;

  digit_store #(.W(CODE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .d(bcd_in),
    .q(stored_q), .shown(shown_q)
  );

  seg_decode u_dec (.code(stored_q), .seg(seg_raw));

  assign dp_raw = (dp_pos == POS_W'(DIGIT_POS));

  seg_drive #(.N(SEG_N + 1)) u_drv (
    .raw({dp_raw, seg_raw}), .off(blank | ~shown_q), .phase(phase), .drv(drv)
  );

  assign seg_out = drv[SEG_N-1:0];
  assign dp_out  = drv[SEG_N];
endmodule

// File: rtl/bcd_digit_driver_chk.sv
module bcd_digit_driver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       blank,
  input logic       phase,
  input logic [3:0] bcd_in,
  input logic [3:0] stored,
  input logic       shown,
  input logic [6:0] seg_out,
  input logic       dp_out
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stored == $past(bcd_in));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(stored));

  a_r4_dark_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && shown && stored > 4'd9) |-> seg_out == {7{phase}});

  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (seg_out == {7{phase}} && dp_out == phase));

  a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase) && !blank && $stable(blank) && shown && $past(shown) && !$past(load))
      |-> seg_out == ~$past(seg_out));

  a_r8_dark_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !shown |-> (seg_out == {7{phase}} && dp_out == phase));
endmodule

bind bcd_digit_driver bcd_digit_driver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .blank(blank), .phase(phase),
  .bcd_in(bcd_in), .stored(stored_q), .shown(shown_q),
  .seg_out(seg_out), .dp_out(dp_out)
);

// File: tb/bcd_digit_driver_test.sv
`timescale 1ns/1ps
module bcd_digit_driver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bcd_in = '0;
  logic load = 1'b0, blank = 1'b0, phase = 1'b0;
  logic [2:0] dp_pos = 3'd2;
  logic [6:0] seg_out;
  logic dp_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_digit_driver uut (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .load(load), .blank(blank),
    .phase(phase), .dp_pos(dp_pos), .seg_out(seg_out), .dp_out(dp_out)
  );

  function automatic logic [6:0] expect_seg(input int c);
    case (c)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int c);
    @(negedge clk); bcd_in = 4'(c); load = 1'b1;
    @(negedge clk); load = 1'b0; #0.5;
  endtask

  task automatic t_reset;
    check("R8 seg after reset", {1'b0, seg_out}, 8'h00);
    check("R8 dp after reset", {7'b0, dp_out}, 8'h00);
    @(negedge clk); bcd_in = 4'd7; #0.5;
    check("R8 dark before first load", {1'b0, seg_out}, 8'h00);
  endtask

  task automatic t_digits;
    for (int c = 0; c < 10; c++) begin
      put(c);
      check($sformatf("R3 R1 digit %0d", c), {1'b0, seg_out}, {1'b0, expect_seg(c)});
    end
    check("R7 dp at own position", {7'b0, dp_out}, 8'h01);
  endtask

  task automatic t_invalid;
    for (int c = 10; c < 16; c++) begin
      put(c);
      check($sformatf("R4 code %0d", c), {1'b0, seg_out}, 8'h00);
    end
  endtask

  task automatic t_hold;
    put(5);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); bcd_in = 4'(c); #0.5;
      check("R2 hold while load low", {1'b0, seg_out}, 8'h6D);
    end
  endtask

  task automatic t_blank;
    put(8);
    @(negedge clk); blank = 1'b1; #0.5;
    check("R5 blank segs", {1'b0, seg_out}, 8'h00);
    check("R5 blank dp", {7'b0, dp_out}, 8'h00);
    @(negedge clk); bcd_in = 4'd3; load = 1'b1;
    @(negedge clk); load = 1'b0; #0.5;
    check("R9 still dark while blank", {1'b0, seg_out}, 8'h00);
    blank = 1'b0; #0.5;
    check("R9 loaded digit after blank", {1'b0, seg_out}, 8'h4F);
  endtask

  task automatic t_phase;
    put(1);
    @(negedge clk); phase = 1'b1; #0.5;
    check("R6 inverted segs", {1'b0, seg_out}, 8'h79);
    check("R6 inverted dp", {7'b0, dp_out}, 8'h00);
    blank = 1'b1; #0.5;
    check("R6 R5 blank inverted", {dp_out, seg_out}, 8'hFF);
    blank = 1'b0; phase = 1'b0; #0.5;
    check("R6 phase back low", {dp_out, seg_out}, 8'h86);
  endtask

  task automatic t_dp;
    @(negedge clk); dp_pos = 3'd1; #0.5;
    check("R7 dp other position", {7'b0, dp_out}, 8'h00);
    dp_pos = 3'd5; #0.5;
    check("R7 dp far position", {7'b0, dp_out}, 8'h00);
    dp_pos = 3'd2; #0.5;
    check("R7 dp own position", {7'b0, dp_out}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    t_reset();
    t_digits();
    t_invalid();
    t_hold();
    t_blank();
    t_phase();
    t_dp();
    done = 1;
  end

  initial begin
    for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule